// File: doc/BRIEF.md
# Vectored Three-Source Interrupt Controller

This block gathers interrupt requests for a small 8-bit processor core from three sources. The first is a falling edge on an external pin. The second is a timer overflow pulse. The third is a pulse marking the end of an analog-to-digital conversion. Each source has a sticky request flag and an individual enable. A master enable gates all three sources together. The flags, the enables and the master enable sit in one 8-bit control register that software reads and writes.

On each rising clock edge where the core's sampling-phase strobe is high, the controller checks whether any enabled flag is pending. It also checks whether the master enable is set and whether the return stack has room. If all of these hold, it picks the highest-priority source and raises a one-cycle call request to the core together with that source's vector address. In the same step it clears that source's flag and the master enable. A return pulse from the core re-arms the master enable.

Top module: `tri_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, and `call_req` and `call_vec` are 0.
- R2: The external pin is passed through two synchronizer flops and then edge-detected. Suppose a high-to-low change on the pin is first sampled at rising edge P1. Then the external flag (control bit 4) reads 1 after edge P3, but only if the external enable (bit 1) is set. If that enable is clear, the falling edge leaves the flag at 0.
- R3: A `tmr_ovf` pulse sets the timer flag (bit 5), and an `adc_done` pulse sets the conversion flag (bit 6). Both take effect at the next edge, whatever the enable bits hold.
- R4: A call is taken at an edge only when `phase_t2` is high, the master enable (bit 0) is set, `stack_full` is low, and at least one source has both its enable and its flag set. `call_req` is then high during the following cycle.
- R5: When several sources are pending, the external source wins over the timer, and the timer wins over the conversion source.
- R6: `call_vec` carries 0x04 for the external source, 0x08 for the timer and 0x0C for the conversion source while `call_req` is high. It carries 0x00 otherwise.
- R7: Taking a call clears the serviced source's flag and the master enable. All other flags and enables keep their values.
- R8: While `stack_full` is high no call is taken, and pending flags remain set until a later permitted edge.
- R9: The control register layout is as follows: bit0 master enable, bit1 external enable, bit2 timer enable, bit3 conversion enable, bit4 external flag, bit5 timer flag, bit6 conversion flag, bit7 reads 0. A write with `csr_we` loads all of bits 0 to 6 directly. A set flag stays set when its enable is cleared.
- R10: A `reti` pulse sets the master enable at the next edge, unless a call is taken at that same edge.
- R11: Pending requests do not cause a call at edges where `phase_t2` is low.
- R12: `call_req` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin (asynchronous, idle high) |
| tmr_ovf | input | 1 | Timer overflow pulse |
| adc_done | input | 1 | Conversion-complete pulse |
| phase_t2 | input | 1 | Sampling-phase strobe; calls are decided only at edges where it is high |
| stack_full | input | 1 | Return stack has no free slot |
| reti | input | 1 | Return-from-interrupt pulse, re-arms master enable |
| csr_we | input | 1 | Control register write strobe |
| csr_wdata | input | 8 | Control register write data |
| csr_rdata | output | 8 | Control register read data |
| call_req | output | 1 | One-cycle call request to the core |
| call_vec | output | 8 | Vector address of the call |

## Verification
The directed part loads all three flags at once and drains them with `reti` between calls. This shows that priority and the vector numbers follow the external, timer, conversion order. It also shows that each call clears only the serviced flag. Separate directed cases hold requests pending while `phase_t2` is low, while `stack_full` is high and while the enable is cleared. These cases tell sampling-phase gating, stack blocking and flag persistence apart from plain masking. A pin edge with its enable clear and then set, checked edge by edge, pins down the synchronizer latency and the enable gating. A long random phase mixes overlapping pulses, pin toggles, register writes and returns in the same cycles as calls. It compares every cycle against a bench model, which exposes wrong precedence between write, set and clear.

// File: rtl/tri_irq_pkg.sv
package tri_irq_pkg;
  localparam int NSRC     = 3;
  localparam int CSR_W    = 8;
  localparam int VEC_W    = 8;
  localparam int VEC_BASE = 4;
  localparam int VEC_STEP = 4;
  localparam int EN_LSB   = 1;
  localparam int FL_LSB   = EN_LSB + NSRC;
  localparam int PAD_W    = CSR_W - FL_LSB - NSRC;

  typedef enum logic [1:0] {
    SRC_EXT = 2'd0,
    SRC_TMR = 2'd1,
    SRC_ADC = 2'd2
  } src_e;

  function automatic logic [VEC_W-1:0] vec_of(input int idx);
    vec_of = VEC_W'(VEC_BASE + idx * VEC_STEP);
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];

  // R2
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import tri_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [CSR_W-1:0] csr_wdata,
  input  logic [NSRC-1:0]  src_evt,
  input  logic [NSRC-1:0]  svc_clr,
  input  logic             svc_take,
  input  logic             reti,
  output logic             gie_q,
  output logic [NSRC-1:0]  en_q,
  output logic [NSRC-1:0]  fl_q
);
  logic            gie_d;
  logic [NSRC-1:0] en_d;
  logic [NSRC-1:0] fl_d;
  logic [NSRC-1:0] fl_base;

  always_comb begin
    if (svc_take)    gie_d = 1'b0;
    else if (reti)   gie_d = 1'b1;
    else if (csr_we) gie_d = csr_wdata[0];
    else             gie_d = gie_q;
    en_d    = csr_we ? csr_wdata[EN_LSB +: NSRC] : en_q;
    fl_base = csr_we ? csr_wdata[FL_LSB +: NSRC] : fl_q;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_comb fl_d[i] = (fl_base[i] & ~svc_clr[i]) | src_evt[i];

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_q[i] && !csr_we && !svc_clr[i]) |=> fl_q[i]);
    // R7
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_clr[i] && !src_evt[i]) |=> !fl_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      en_q  <= '0;
      fl_q  <= '0;
    end else begin
      gie_q <= gie_d;
      en_q  <= en_d;
      fl_q  <= fl_d;
    end
  end

  // R10
  reti_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !svc_take) |=> gie_q);
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import tri_irq_pkg::*;
(
  input  logic [NSRC-1:0]  pend,
  output logic [NSRC-1:0]  grant,
  output logic             any,
  output logic [VEC_W-1:0] vec
);
  logic [NSRC:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < NSRC; i++) begin : g_chain
    assign grant[i]     = pend[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | pend[i];
  end

  assign any = blocked[NSRC];

  always_comb begin
    vec = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) vec = vec | vec_of(i);
    end
  end

  // R5
  always_comb begin
    grant_onehot_chk: assert ($onehot0(grant));
  end
endmodule

// File: rtl/tri_irq_ctrl.sv
module tri_irq_ctrl
  import tri_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_pin,
  input  logic             tmr_ovf,
  input  logic             adc_done,
  input  logic             phase_t2,
  input  logic             stack_full,
  input  logic             reti,
  input  logic             csr_we,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec
);
  logic             ext_fall;
  logic             gie_q;
  logic [NSRC-1:0]  en_q;
  logic [NSRC-1:0]  fl_q;
  logic [NSRC-1:0]  src_evt;
  logic [NSRC-1:0]  pend;
  logic [NSRC-1:0]  grant;
  logic             any_pend;
  logic [VEC_W-1:0] sel_vec;
  logic             take;
  logic [NSRC-1:0]  svc_clr;
  logic             call_d;
  logic [VEC_W-1:0] vec_d;
  logic             call_q;
  logic [VEC_W-1:0] vec_q;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ext_pin),
    .fall (ext_fall)
  );

  always_comb begin
    src_evt          = '0;
    src_evt[SRC_EXT] = ext_fall & en_q[SRC_EXT];
    src_evt[SRC_TMR] = tmr_ovf;
    src_evt[SRC_ADC] = adc_done;
  end

  assign pend = en_q & fl_q;

  irq_prio_sel u_prio (
    .pend (pend),
    .grant(grant),
    .any  (any_pend),
    .vec  (sel_vec)
  );

  always_comb begin
    take    = phase_t2 & gie_q & ~stack_full & any_pend;
    svc_clr = take ? grant : '0;
    call_d  = take;
    vec_d   = take ? sel_vec : '0;
  end

  irq_flag_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .csr_we   (csr_we),
    .csr_wdata(csr_wdata),
    .src_evt  (src_evt),
    .svc_clr  (svc_clr),
    .svc_take (take),
    .reti     (reti),
    .gie_q    (gie_q),
    .en_q     (en_q),
    .fl_q     (fl_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      call_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      call_q <= call_d;
      vec_q  <= vec_d;
    end
  end

  assign call_req  = call_q;
  assign call_vec  = vec_q;
  assign csr_rdata = {{PAD_W{1'b0}}, fl_q, en_q, gie_q};

  // R12
  call_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> !call_req);
  // R8
  call_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !$past(stack_full));
  // R11
  call_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(phase_t2));
  // R6
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (call_vec == vec_of(0) || call_vec == vec_of(1) || call_vec == vec_of(2)));
  // R7
  gie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !gie_q);
endmodule

// File: tb/tri_irq_ctrl_test.sv
module tri_irq_ctrl_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic ext_pin, tmr_ovf, adc_done, phase_t2, stack_full, reti, csr_we;
  logic [7:0] csr_wdata;
  logic [7:0] csr_rdata;
  logic call_req;
  logic [7:0] call_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(PERIOD/2) clk = ~clk;

  tri_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
    .adc_done(adc_done), .phase_t2(phase_t2), .stack_full(stack_full),
    .reti(reti), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .call_req(call_req), .call_vec(call_vec)
  );

  // Bench model built from the requirements
  logic       m_s1, m_s2, m_prev, m_gie, m_call;
  logic [2:0] m_en, m_fl;
  logic [7:0] m_vec;

  function automatic logic [7:0] vec_for(input int idx);
    return 8'(4 + 4 * idx);
  endfunction

  function automatic int pick(input logic [2:0] p);
    for (int i = 0; i < 3; i++) if (p[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] model_rd();
    return {1'b0, m_fl, m_en, m_gie};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_prev = 1; m_gie = 0; m_en = 0; m_fl = 0;
      m_call = 0; m_vec = 0;
    end else begin
      logic fall, tk;
      logic [2:0] fl_n, ev;
      int idx;
      fall = m_prev & ~m_s2;
      idx  = pick(m_en & m_fl);
      tk   = phase_t2 & m_gie & ~stack_full & (idx >= 0);
      fl_n = csr_we ? csr_wdata[6:4] : m_fl;
      if (tk) fl_n[idx] = 1'b0;
      ev   = {adc_done, tmr_ovf, fall & m_en[0]};
      fl_n = fl_n | ev;
      if (tk)          m_gie = 0;
      else if (reti)   m_gie = 1;
      else if (csr_we) m_gie = csr_wdata[0];
      if (csr_we) m_en = csr_wdata[3:1];
      m_fl   = fl_n;
      m_call = tk;
      m_vec  = tk ? vec_for(idx) : 8'h00;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    tmr_ovf = 0; adc_done = 0; phase_t2 = 0; stack_full = 0; reti = 0;
    csr_we = 0; csr_wdata = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    csr_we = 1; csr_wdata = d; cyc(); idle();
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; ext_pin = 1; idle();
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1
    chk("R1 rdata", csr_rdata, 8'h00);
    chk("R1 call", {call_req, call_vec}, 9'h0);

    // R9 layout and direct write, R11 no call without phase
    wr(8'h7F);
    chk("R9 layout", csr_rdata, 8'h7F);
    cyc();
    chk("R11 no phase", call_req, 1'b0);
    // R8 stack full blocks
    phase_t2 = 1; stack_full = 1; cyc(); idle();
    chk("R8 blocked", call_req, 1'b0);
    chk("R8 still pending", csr_rdata, 8'h7F);
    // R4 R5 R6 R7 external first
    phase_t2 = 1; cyc(); idle();
    chk("R4 call", call_req, 1'b1);
    chk("R6 ext vec", call_vec, 8'h04);
    chk("R7 clears ext+gie", csr_rdata, 8'h6E);
    cyc();
    chk("R12 single", call_req, 1'b0);
    // R10 reti re-arms
    reti = 1; cyc(); idle();
    chk("R10 rearm", csr_rdata, 8'h6F);
    phase_t2 = 1; cyc(); idle();
    chk("R5 timer next", call_vec, 8'h08);
    chk("R7 clears tmr", csr_rdata, 8'h4E);
    reti = 1; cyc(); idle();
    phase_t2 = 1; cyc(); idle();
    chk("R5 adc last", call_vec, 8'h0C);
    chk("R7 clears adc", csr_rdata, 8'h0E);

    // R9 flag persists with enable cleared
    wr(8'h21);
    phase_t2 = 1; cyc(); idle();
    chk("R9 masked no call", call_req, 1'b0);
    chk("R9 flag kept", csr_rdata, 8'h21);
    wr(8'h25);
    phase_t2 = 1; cyc(); idle();
    chk("R4 unmasked call", call_vec, 8'h08);

    // R3 pulses set flags regardless of enables
    wr(8'h00);
    tmr_ovf = 1; cyc(); idle();
    chk("R3 tmr flag", csr_rdata, 8'h20);
    adc_done = 1; cyc(); idle();
    chk("R3 adc flag", csr_rdata, 8'h60);
    wr(8'h00);

    // R2 edge ignored when disabled
    ext_pin = 0; repeat (5) cyc();
    chk("R2 disabled", csr_rdata[4], 1'b0);
    ext_pin = 1; repeat (4) cyc();
    wr(8'h02);
    ext_pin = 0; cyc();      // P1
    cyc();                   // P2
    chk("R2 not yet", csr_rdata, 8'h02);
    cyc();                   // P3
    chk("R2 ext flag", csr_rdata, 8'h12);
    ext_pin = 1; repeat (4) cyc();

    // Random phase against the bench model
    for (int n = 0; n < 3000; n++) begin
      cyc();
      chk("R9 rdata model", csr_rdata, model_rd());
      chk("R4 call model", {call_req, call_vec}, {m_call, m_vec});
      if ($urandom_range(0, 7) == 0) ext_pin = ~ext_pin;
      tmr_ovf    = ($urandom_range(0, 9) == 0);
      adc_done   = ($urandom_range(0, 9) == 0);
      phase_t2   = ($urandom_range(0, 3) == 0);
      stack_full = ($urandom_range(0, 4) == 0);
      reti       = ($urandom_range(0, 7) == 0);
      csr_we     = ($urandom_range(0, 11) == 0);
      csr_wdata  = 8'($urandom);
    end
    cyc();
    chk("R9 final model", csr_rdata, model_rd());

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule